// File: doc/BRIEF.md
# Dirty-Line Page Buffer Write-Back Controller

This block keeps the tag state for a page-granular DRAM buffer placed in front of a slow main memory with limited write endurance. Each buffer frame records a valid bit, the resident page number, a flag that says whether main memory already holds a copy of the page, and one dirty bit for each of the page's 16 lines. The buffer is set-associative: the low bits of the page number pick the set. A least-recently-used order within each set picks the frame to replace.

Processor-side line requests that hit are accepted at once. The frame index and line index are returned one cycle later so that an external data array can be addressed. A miss holds the request and evicts a frame. Only the lines that main memory lacks go into a write queue, one line per accepted queue cycle, with the line data read from the external data array. The frame is then cleared and the missing page is fetched. The fetched page is written into the buffer only. Main memory receives it later, when that frame is evicted. A page that is loaded and then modified therefore costs one main-memory write instead of two.

Top module: `pbuf_ctrl`

## Requirements
- R1: After reset every frame is invalid, and wq_valid, fetch_valid, resp_valid and req_ready are all low.
- R2: On a miss, when the chosen frame is invalid, no line is queued. A fetch is issued with fetch_page equal to the requested page and fetch_frame = set*WAYS + way, where set = page mod SETS. Fetches happen only on misses.
- R3: A request to a resident page is accepted in the same cycle (req_ready high). In the next cycle resp_valid is high, with resp_frame = set*WAYS + way and resp_line equal to the requested line. After a fetch completes, the held request is accepted as a hit.
- R4: An accepted write sets only the dirty bit of the line it addresses. An accepted read sets none.
- R5: When the evicted page has a main-memory copy, exactly its dirty lines are queued, in ascending line order. Each queued line carries the victim page number, the line index and the data-array word for that frame and line.
- R6: When the evicted page has a main-memory copy and no dirty line, nothing is queued.
- R7: When the evicted page has no main-memory copy (fetch_in_mem was 0 at its install), all 16 lines, 0 to 15, are queued whatever their dirty bits.
- R8: While wq_valid is high and wq_ready is low, wq_line and wq_page hold. While lines remain to be queued, req_ready stays low.
- R9: The victim is the lowest-numbered invalid way of the set. If every way is valid, the victim is the least recently accepted way.
- R10: Eviction clears the frame's valid, present and dirty state before the new page is installed. The new page starts with no dirty line and with its present flag equal to fetch_in_mem.
- R11: The fetch is issued only after the last needed line has been accepted by the queue, and fetch_valid holds until fetch_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor line request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_page | input | PAGE_W | Page number of the request |
| req_line | input | 4 | Line index within the page |
| req_ready | output | 1 | Request accepted this cycle (hit) |
| resp_valid | output | 1 | Response for the request accepted last cycle |
| resp_frame | output | FR_W | Buffer frame holding the line |
| resp_line | output | 4 | Line index of the response |
| fetch_valid | output | 1 | Page fetch request to backing storage |
| fetch_page | output | PAGE_W | Page to fetch |
| fetch_frame | output | FR_W | Frame that receives the page |
| fetch_ready | input | 1 | Fetch request taken |
| fetch_done | input | 1 | Fetched page has been placed in the data array |
| fetch_in_mem | input | 1 | Fetched page already has a main-memory copy |
| arr_rd_frame | output | FR_W | Data array read frame for a write-back |
| arr_rd_line | output | 4 | Data array read line for a write-back |
| arr_rd_data | input | DATA_W | Data array read word (same cycle) |
| wq_valid | output | 1 | Write-queue entry valid |
| wq_page | output | PAGE_W | Page number of the queued line |
| wq_line | output | 4 | Line index of the queued line |
| wq_data | output | DATA_W | Data of the queued line |
| wq_ready | input | 1 | Write queue accepts the entry |

## Verification
A dirty bit that is set wrongly or lost does not show until its frame is evicted. It then appears as an extra, missing or out-of-order queue entry, possibly many requests later. A corrupted valid bit, page number or present flag shows on the very next request to that set: a hit is turned into a fetch or a fetch into a hit, or a clean page is drained in full. A wrong replacement order shows on fetch_frame at the first miss in a full set. The bench therefore keeps its own model of every frame. On each request it predicts the fetch target, the exact queued lines with their data, and the response frame.

// File: rtl/pb_pkg.sv
package pb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_CLEAR,
    ST_FETCH,
    ST_WAITF
  } pb_state_e;

  // Frame index of a (set, way) pair in the flat buffer.
  function automatic int unsigned frame_of(int unsigned set_idx, int unsigned way_idx,
                                           int unsigned ways);
    return set_idx * ways + way_idx;
  endfunction

  // A line must reach main memory if the page has no copy there or the line is dirty.
  function automatic logic line_needed(logic present, logic dirty);
    return !present || dirty;
  endfunction

endpackage

// File: rtl/pb_tag_store.sv
module pb_tag_store #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int LINES  = 16,
  parameter int PAGE_W = 12,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int LN_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  set_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [WAY_W-1:0]  way_i,
  output logic              hit_o,
  output logic [WAY_W-1:0]  hit_way_o,
  output logic [WAYS-1:0]   valid_o,
  output logic              present_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [LINES-1:0]  dirty_o,
  input  logic              mark_en,
  input  logic [LN_W-1:0]   mark_line,
  input  logic              clear_en,
  input  logic              fill_en,
  input  logic              fill_present
);

  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAYS-1:0]   pres_q [SETS];
  logic [PAGE_W-1:0] pg_q   [SETS][WAYS];
  logic [LINES-1:0]  dty_q  [SETS][WAYS];
  logic [WAYS-1:0]   match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld_q[set_i][w] && (pg_q[set_i][w] == page_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) hit_way_o = WAY_W'(w);
  end

  assign hit_o     = |match;
  assign valid_o   = vld_q[set_i];
  assign present_o = pres_q[set_i][way_i];
  assign page_o    = pg_q[set_i][way_i];
  assign dirty_o   = dty_q[set_i][way_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        pres_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) dty_q[s][w] <= '0;
      end
    end else begin
      if (clear_en) begin
        vld_q[set_i][way_i]  <= 1'b0;
        pres_q[set_i][way_i] <= 1'b0;
        dty_q[set_i][way_i]  <= '0;
      end
      if (fill_en) begin
        vld_q[set_i][way_i]  <= 1'b1;
        pres_q[set_i][way_i] <= fill_present;
        dty_q[set_i][way_i]  <= '0;
      end
      if (mark_en) dty_q[set_i][way_i][mark_line] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) pg_q[set_i][way_i] <= page_i;
  end

endmodule

// File: rtl/pb_lru.sv
module pb_lru #(
  parameter int SETS = 4,
  parameter int WAYS = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [WAYS-1:0]  valid_i,
  output logic [WAY_W-1:0] victim_o
);

  // Age 0 = most recent, WAYS-1 = least recent; ages of a set stay a permutation.
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < age_q[set_i][touch_way_i])
          age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (!found && !valid_i[w]) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    for (int w = 0; w < WAYS; w++)
      if (!found && age_q[set_i][w] == WAY_W'(WAYS - 1)) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
  end

endmodule

// File: rtl/pb_drain.sv
module pb_drain #(
  parameter int LINES = 16,
  localparam int LN_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             en_i,
  input  logic             present_i,
  input  logic [LINES-1:0] dirty_i,
  input  logic             ready_i,
  output logic [LN_W-1:0]  line_o,
  output logic             need_o,
  output logic             advance_o,
  output logic             last_o
);

  logic [LN_W-1:0] cnt_q;

  assign line_o    = cnt_q;
  assign need_o    = en_i && pb_pkg::line_needed(present_i, dirty_i[cnt_q]);
  assign advance_o = en_i && (!need_o || ready_i);
  assign last_o    = advance_o && (cnt_q == LN_W'(LINES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (start_i)   cnt_q <= '0;
    else if (advance_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/pbuf_ctrl.sv
module pbuf_ctrl #(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int LINES  = 16,
  parameter int PAGE_W = 12,
  parameter int DATA_W = 32,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int LN_W  = $clog2(LINES),
  localparam int FR_W  = $clog2(SETS * WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [LN_W-1:0]   req_line,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [FR_W-1:0]   resp_frame,
  output logic [LN_W-1:0]   resp_line,
  output logic              fetch_valid,
  output logic [PAGE_W-1:0] fetch_page,
  output logic [FR_W-1:0]   fetch_frame,
  input  logic              fetch_ready,
  input  logic              fetch_done,
  input  logic              fetch_in_mem,
  output logic [FR_W-1:0]   arr_rd_frame,
  output logic [LN_W-1:0]   arr_rd_line,
  input  logic [DATA_W-1:0] arr_rd_data,
  output logic              wq_valid,
  output logic [PAGE_W-1:0] wq_page,
  output logic [LN_W-1:0]   wq_line,
  output logic [DATA_W-1:0] wq_data,
  input  logic              wq_ready
);

  pb_pkg::pb_state_e state_q;
  logic [PAGE_W-1:0] miss_page_q;
  logic [WAY_W-1:0]  vic_way_q;
  logic              resp_valid_q;
  logic [FR_W-1:0]   resp_frame_q;
  logic [LN_W-1:0]   resp_line_q;

  logic              in_idle, hit, vic_valid;
  logic [WAY_W-1:0]  hit_way, victim, cur_way;
  logic [SET_W-1:0]  req_set, cur_set;
  logic [PAGE_W-1:0] cur_page, vic_page;
  logic [WAYS-1:0]   set_valid;
  logic              vic_present;
  logic [LINES-1:0]  vic_dirty;
  logic [FR_W-1:0]   vic_frame;
  logic              drain_need, drain_adv, drain_last;
  logic [LN_W-1:0]   drain_line;

  // Named internal events
  logic hit_acc, miss_start, clear_evt, fill_evt, line_emit;

  assign in_idle    = (state_q == pb_pkg::ST_IDLE);
  assign req_set    = req_page[SET_W-1:0];
  assign cur_set    = in_idle ? req_set : miss_page_q[SET_W-1:0];
  assign cur_way    = in_idle ? hit_way : vic_way_q;
  assign cur_page   = in_idle ? req_page : miss_page_q;
  assign hit_acc    = in_idle && req_valid && hit;
  assign miss_start = in_idle && req_valid && !hit;
  assign clear_evt  = (state_q == pb_pkg::ST_CLEAR);
  assign fill_evt   = (state_q == pb_pkg::ST_WAITF) && fetch_done;
  assign vic_valid  = set_valid[victim];
  assign vic_frame  = FR_W'(pb_pkg::frame_of(32'(miss_page_q[SET_W-1:0]), 32'(vic_way_q), WAYS));

  pb_tag_store #(.SETS(SETS), .WAYS(WAYS), .LINES(LINES), .PAGE_W(PAGE_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .set_i(cur_set), .page_i(cur_page), .way_i(cur_way),
    .hit_o(hit), .hit_way_o(hit_way), .valid_o(set_valid), .present_o(vic_present),
    .page_o(vic_page), .dirty_o(vic_dirty),
    .mark_en(hit_acc && req_write), .mark_line(req_line),
    .clear_en(clear_evt), .fill_en(fill_evt), .fill_present(fetch_in_mem)
  );

  pb_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n), .set_i(cur_set), .touch_i(hit_acc),
    .touch_way_i(hit_way), .valid_i(set_valid), .victim_o(victim)
  );

  pb_drain #(.LINES(LINES)) u_drain (
    .clk(clk), .rst_n(rst_n), .start_i(miss_start),
    .en_i(state_q == pb_pkg::ST_DRAIN), .present_i(vic_present), .dirty_i(vic_dirty),
    .ready_i(wq_ready), .line_o(drain_line), .need_o(drain_need),
    .advance_o(drain_adv), .last_o(drain_last)
  );

  assign line_emit    = drain_need && wq_ready;
  assign req_ready    = hit_acc;
  assign resp_valid   = resp_valid_q;
  assign resp_frame   = resp_frame_q;
  assign resp_line    = resp_line_q;
  assign wq_valid     = drain_need;
  assign wq_page      = vic_page;
  assign wq_line      = drain_line;
  assign wq_data      = arr_rd_data;
  assign arr_rd_frame = vic_frame;
  assign arr_rd_line  = drain_line;
  assign fetch_valid  = (state_q == pb_pkg::ST_FETCH);
  assign fetch_page   = miss_page_q;
  assign fetch_frame  = vic_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= pb_pkg::ST_IDLE;
      miss_page_q  <= '0;
      vic_way_q    <= '0;
      resp_valid_q <= 1'b0;
      resp_frame_q <= '0;
      resp_line_q  <= '0;
    end else begin
      resp_valid_q <= hit_acc;
      if (hit_acc) begin
        resp_frame_q <= FR_W'(pb_pkg::frame_of(32'(req_set), 32'(hit_way), WAYS));
        resp_line_q  <= req_line;
      end
      unique case (state_q)
        pb_pkg::ST_IDLE:
          if (miss_start) begin
            miss_page_q <= req_page;
            vic_way_q   <= victim;
            state_q     <= vic_valid ? pb_pkg::ST_DRAIN : pb_pkg::ST_CLEAR;
          end
        pb_pkg::ST_DRAIN: if (drain_last)  state_q <= pb_pkg::ST_CLEAR;
        pb_pkg::ST_CLEAR:                  state_q <= pb_pkg::ST_FETCH;
        pb_pkg::ST_FETCH: if (fetch_ready) state_q <= pb_pkg::ST_WAITF;
        pb_pkg::ST_WAITF: if (fetch_done)  state_q <= pb_pkg::ST_IDLE;
        default:                           state_q <= pb_pkg::ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pbuf_ctrl_chk.sv
module pbuf_ctrl_chk #(
  parameter int PAGE_W = 12,
  parameter int LN_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              wq_valid,
  input logic              wq_ready,
  input logic [LN_W-1:0]   wq_line,
  input logic [PAGE_W-1:0] wq_page,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic              miss_start,
  input logic              clear_evt,
  input logic              fill_evt
);

  AST_WQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wq_valid && !wq_ready |=> wq_valid && $stable(wq_line) && $stable(wq_page)); // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wq_valid || fetch_valid) |-> !req_ready); // R8
  AST_MISS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    miss_start |=> !req_ready); // R8
  AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid); // R3
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !resp_valid); // R3
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid); // R11
  AST_QUEUE_BEFORE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    wq_valid |-> !fetch_valid); // R11
  AST_CLEAR_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> fetch_valid); // R10
  AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> !wq_valid && !fetch_valid); // R10

endmodule

bind pbuf_ctrl pbuf_ctrl_chk #(.PAGE_W(PAGE_W), .LN_W(LN_W)) u_chk (.*);

// File: tb/pbuf_ctrl_tb.sv
`timescale 1ns/1ps
module pbuf_ctrl_tb;
  localparam int SETS = 4, WAYS = 2, LINES = 16, PAGE_W = 12, DATA_W = 32;
  localparam int FR_W = $clog2(SETS * WAYS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_ready;
  logic [PAGE_W-1:0] req_page = '0;
  logic [3:0] req_line = '0;
  logic resp_valid;
  logic [FR_W-1:0] resp_frame;
  logic [3:0] resp_line;
  logic fetch_valid, fetch_ready = 0, fetch_done = 0, fetch_in_mem = 0;
  logic [PAGE_W-1:0] fetch_page;
  logic [FR_W-1:0] fetch_frame, arr_rd_frame;
  logic [3:0] arr_rd_line, wq_line;
  logic [DATA_W-1:0] arr_rd_data, wq_data;
  logic wq_valid, wq_ready = 0;
  logic [PAGE_W-1:0] wq_page;

  int n_chk = 0, n_fail = 0;

  int          mpg  [SETS][WAYS];
  bit          mval [SETS][WAYS];
  bit          mpres[SETS][WAYS];
  logic [15:0] mdty [SETS][WAYS];
  int          mru  [SETS];

  function automatic int dfun(int fr, int ln);
    return 32'h5A00 + fr * 16 + ln;
  endfunction

  always_comb arr_rd_data = 32'(dfun(int'(arr_rd_frame), int'(arr_rd_line)));

  pbuf_ctrl #(.SETS(SETS), .WAYS(WAYS), .LINES(LINES), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic access(input int pg, input bit wr, input int ln, input bit inmem, input bit stall);
    int s, hw, vw, w, got, cyc, nexp, prev_line;
    int exp_l[16];
    bit fetched, fd_now, acc, prev_stall;
    string rq;
    s = pg % SETS; hw = -1; vw = 0; got = 0; cyc = 0; nexp = 0; prev_line = 0;
    fetched = 0; fd_now = 0; acc = 0; prev_stall = 0;
    for (int k = 0; k < WAYS; k++) if (mval[s][k] && mpg[s][k] == pg) hw = k;
    if (hw < 0) begin
      vw = !mval[s][0] ? 0 : (!mval[s][1] ? 1 : 1 - mru[s]);
      if (mval[s][vw])
        for (int l = 0; l < LINES; l++)
          if (!mpres[s][vw] || mdty[s][vw][l]) begin exp_l[nexp] = l; nexp++; end
    end
    rq = (hw >= 0) ? "R3" : (!mval[s][vw]) ? "R2" : (!mpres[s][vw]) ? "R7" :
         (nexp == 0) ? "R6 R10" : "R4 R5";
    req_valid = 1; req_write = wr; req_page = PAGE_W'(pg); req_line = 4'(ln);
    while (!acc && cyc < 400) begin
      wq_ready     = stall ? (cyc % 3 == 2) : 1'b1;
      fetch_ready  = stall ? (cyc % 2 == 1) : 1'b1;
      fetch_done   = fd_now;
      fetch_in_mem = inmem;
      #1;
      if (wq_valid) begin
        chk(!req_ready, "R8", "ready during drain", int'(req_ready), 0);
        if (prev_stall) chk(int'(wq_line) == prev_line, "R8", "line held under backpressure", int'(wq_line), prev_line);
        if (wq_ready) begin
          if (got < nexp) begin
            chk(int'(wq_line) == exp_l[got], rq, "queued line", int'(wq_line), exp_l[got]);
            chk(int'(wq_page) == mpg[s][vw], rq, "queued page", int'(wq_page), mpg[s][vw]);
            chk(int'(wq_data) == dfun(s * WAYS + vw, exp_l[got]), rq, "queued data",
                int'(wq_data), dfun(s * WAYS + vw, exp_l[got]));
          end else chk(0, rq, "extra queued line", int'(wq_line), -1);
          got++;
        end
        prev_stall = !wq_ready; prev_line = int'(wq_line);
      end else prev_stall = 0;
      fd_now = 0;
      if (fetch_valid && fetch_ready) begin
        chk(int'(fetch_page) == pg, "R2", "fetch page", int'(fetch_page), pg);
        chk(int'(fetch_frame) == s * WAYS + vw, mval[s][vw] ? "R9" : "R2", "fetch frame",
            int'(fetch_frame), s * WAYS + vw);
        chk(got == nexp, "R11", "fetch only after full drain", got, nexp);
        fetched = 1; fd_now = 1;
      end
      acc = req_ready;
      @(negedge clk);
      cyc++;
    end
    fetch_done = 0;
    w = (hw >= 0) ? hw : vw;
    chk(acc, rq, "request accepted", int'(acc), 1);
    chk(resp_valid, "R3", "resp valid", int'(resp_valid), 1);
    chk(int'(resp_frame) == s * WAYS + w, "R3", "resp frame", int'(resp_frame), s * WAYS + w);
    chk(int'(resp_line) == ln, "R3", "resp line", int'(resp_line), ln);
    chk(fetched == (hw < 0), "R2", "fetch iff miss", int'(fetched), int'(hw < 0));
    chk(got == nexp, rq, "number of queued lines", got, nexp);
    req_valid = 0;
    if (hw < 0) begin
      mval[s][w] = 1; mpg[s][w] = pg; mpres[s][w] = inmem; mdty[s][w] = '0;
    end
    if (wr) mdty[s][w][ln] = 1'b1;
    mru[s] = w;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] masks [8];
    int k, s, base;
    masks = '{16'h0000, 16'h0001, 16'h8000, 16'h8001, 16'hAAAA, 16'h5555, 16'h0FF0, 16'hFFFF};
    for (int a = 0; a < SETS; a++) begin
      mru[a] = 0;
      for (int b = 0; b < WAYS; b++) begin mval[a][b] = 0; mpres[a][b] = 0; mdty[a][b] = '0; mpg[a][b] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!wq_valid, "R1", "wq_valid after reset", int'(wq_valid), 0);
    chk(!fetch_valid, "R1", "fetch_valid after reset", int'(fetch_valid), 0);
    chk(!resp_valid, "R1", "resp_valid after reset", int'(resp_valid), 0);
    chk(!req_ready, "R1", "req_ready after reset", int'(req_ready), 0);
    // Directed sweep: dirty masks x install source x queue backpressure
    k = 0;
    for (int i = 0; i < 8; i++)
      for (int im = 0; im < 2; im++)
        for (int st = 0; st < 2; st++) begin
          s = k % SETS; base = 4 * (8 * k + 4);
          access(base + s, 0, 3, im[0], st[0]);
          for (int l = 0; l < LINES; l++)
            if (masks[i][l]) access(base + s, 1, l, im[0], st[0]);
          access(base + 4 + s, 0, 0, 1, st[0]);
          access(base + 8 + s, 0, 5, 1, st[0]);
          access(base + 12 + s, 1, 2, 1, st[0]);
          access(base + 16 + s, 0, 7, 1, st[0]);
          k++;
        end
    // Random traffic over three pages per set
    void'($urandom(11));
    for (int r = 0; r < 400; r++)
      access(int'($urandom % 12), $urandom % 2 == 1, int'($urandom % 16),
             $urandom % 2 == 1, $urandom % 2 == 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule